// File: doc/BRIEF.md
# Parallel Output Handshake Sequencer

This block moves words from a small internal FIFO onto a parallel output port and paces each transfer in one of three ways. In the two paced modes a one-cycle pacer tick releases each word. The tick either just updates the data lines, or also produces a fixed-width request strobe. In handshake mode the block shows a word, raises a request and holds it until the external receiver acknowledges. It takes the next word only after that acknowledge has been released.

The host fills the FIFO through a simple push port and selects the mode. A level run control starts and stops the sequencer. A separate trigger output follows a host-written bit. A sticky flag records any pacer tick that found the FIFO empty. The acknowledge input is asynchronous and passes through a two-flop synchroniser.

Top module: `par_out_seq`

## Requirements
- R1: After reset the request output is low, the data output is zero, the trigger output is low, the underrun flag is clear, the FIFO reports empty and not full.
- R2: A push is stored when the FIFO is not full, and words leave in push order. The full flag is high once DEPTH words are held. A push while full is dropped and changes neither stored contents nor order.
- R3: With mode 2'b00, a tick seen while the sequencer is idle and the FIFO holds data pops one word. That word appears on the data output after the second rising edge from the tick's sampling edge. The request output stays low.
- R4: With mode 2'b01, a word is shown as in R3 and the request rises one cycle later. The request stays high for exactly STROBE_CYC cycles. A tick that arrives while the strobe is active is ignored and pops nothing.
- R5: With mode 2'b10 or 2'b11, the sequencer pops a word only while the synchronised acknowledge is low. It drives the data one cycle before raising the request and holds the request until the acknowledge is seen.
- R6: After the acknowledge input rises, the request falls on the third rising edge (two synchroniser stages plus one decision stage).
- R7: After the request falls in handshake mode, no new request is raised while the acknowledge stays high.
- R8: The data output does not change while the request is high.
- R9: In a paced mode, a tick seen while idle with an empty FIFO sets the underrun flag and leaves the data output unchanged. The flag stays set until reset.
- R10: When run is low, the request falls on the next edge and no word is popped. Words still in the FIFO are kept for later transfers.
- R11: A write to the trigger bit drives the trigger output to the written value on the next edge. The output holds its value while no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Sequencer enable; low stops it and drops the request |
| mode_sel | input | 2 | 00 tick only, 01 tick with request strobe, 1x handshake |
| tick | input | 1 | One-cycle pacer pulse |
| push_valid | input | 1 | Push a word into the FIFO |
| push_data | input | DATA_W | Word to push |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_empty | output | 1 | FIFO holds no word |
| trig_we | input | 1 | Write strobe for the trigger bit |
| trig_val | input | 1 | Value written to the trigger bit |
| trig_out | output | 1 | Trigger output |
| ack_in | input | 1 | Asynchronous acknowledge from the receiver |
| req_out | output | 1 | Request to the receiver |
| data_out | output | DATA_W | Parallel output data |
| underrun | output | 1 | Sticky flag: a paced tick found the FIFO empty |

## Verification
A wrong sequencer state shows up on the request and data lines within a few cycles of the stimulus that exposes it. A misrouted tick or acknowledge produces a request edge or a data update one cycle early or late. A lost or duplicated pop shifts every later word on the data output against the pushed order. A miscounting strobe or synchroniser changes the measured request width or the three-edge release latency. A stop that does not take effect leaves the request high one edge after run falls, or removes a word that a later paced transfer should have delivered.

// File: rtl/par_out_pkg.sv
package par_out_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ARM,
    ST_STROBE,
    ST_HOLD
  } seq_state_t;

  localparam logic [1:0] MODE_TICK   = 2'b00;
  localparam logic [1:0] MODE_STROBE = 2'b01;

endpackage

// File: rtl/pos_fifo.sv
module pos_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW:0]       wr_ptr, rd_ptr;
  logic              wr_en;

  assign empty = (wr_ptr == rd_ptr);
  assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign wr_en = wr_req && !full;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr[AW-1:0]] <= wr_data;
    if (rd_en) rd_data <= mem[rd_ptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full) |=> $stable(wr_ptr));

  // R2
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);

endmodule

// File: rtl/pos_sync.sv
module pos_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pos_ctrl.sv
module pos_ctrl
  import par_out_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STROBE_CYC = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [1:0]        mode,
  input  logic              tick,
  input  logic              ack_s,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_rdata,
  output logic              pop,
  output logic [DATA_W-1:0] data_out,
  output logic              req_out,
  output logic              underrun
);
  localparam int CW = $clog2(STROBE_CYC + 1) + 1;

  seq_state_t    state;
  logic [CW-1:0] cnt;
  logic          hs;
  logic          due;

  assign hs  = mode[1];
  assign due = hs ? !ack_s : tick;
  assign pop = run && (state == ST_IDLE) && due && !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      data_out <= '0;
      req_out  <= 1'b0;
      cnt      <= '0;
      underrun <= 1'b0;
    end else if (!run) begin
      state   <= ST_IDLE;
      req_out <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pop)                  state    <= ST_LOAD;
          else if (!hs && tick)     underrun <= 1'b1;
        end
        ST_LOAD: begin
          data_out <= fifo_rdata;
          state    <= (mode == MODE_TICK) ? ST_IDLE : ST_ARM;
        end
        ST_ARM: begin
          req_out <= 1'b1;
          cnt     <= CW'(1);
          state   <= hs ? ST_HOLD : ST_STROBE;
        end
        ST_STROBE: begin
          if (cnt == CW'(STROBE_CYC)) begin
            req_out <= 1'b0;
            state   <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (ack_s) begin
            req_out <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // width monitor for the strobe check
  logic [CW-1:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst)          hi_cnt <= '0;
    else if (req_out) hi_cnt <= hi_cnt + 1'b1;
    else              hi_cnt <= '0;
  end

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_out && $past(req_out)) |-> $stable(data_out));

  // R4
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(req_out) && $past(run) && mode == MODE_STROBE) |-> hi_cnt == CW'(STROBE_CYC));

  // R10
  stop_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !req_out);

  // R9
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(req_out) && $past(run) && hs) |-> $past(ack_s));

endmodule

// File: rtl/par_out_seq.sv
module par_out_seq #(
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 16,
  parameter int STROBE_CYC = 5,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_en,
  input  logic [1:0]        mode_sel,
  input  logic              tick,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              fifo_full,
  output logic              fifo_empty,
  input  logic              trig_we,
  input  logic              trig_val,
  output logic              trig_out,
  input  logic              ack_in,
  output logic              req_out,
  output logic [DATA_W-1:0] data_out,
  output logic              underrun
);
  logic              pop;
  logic              ack_s;
  logic [DATA_W-1:0] rd_data;

  pos_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_req  (push_valid),
    .wr_data (push_data),
    .rd_en   (pop),
    .rd_data (rd_data),
    .full    (fifo_full),
    .empty   (fifo_empty)
  );

  pos_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_in),
    .q   (ack_s)
  );

  pos_ctrl #(.DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .run        (run_en),
    .mode       (mode_sel),
    .tick       (tick),
    .ack_s      (ack_s),
    .fifo_empty (fifo_empty),
    .fifo_rdata (rd_data),
    .pop        (pop),
    .data_out   (data_out),
    .req_out    (req_out),
    .underrun   (underrun)
  );

  always_ff @(posedge clk) begin
    if (rst)          trig_out <= 1'b0;
    else if (trig_we) trig_out <= trig_val;
  end

  // R11
  trig_follow_chk: assert property (@(posedge clk) disable iff (rst)
    trig_we |=> trig_out == $past(trig_val));

endmodule

// File: tb/tb_par_out_seq.sv
module tb_par_out_seq;
  localparam int DW = 32;
  localparam int DEPTH = 16;
  localparam int SC = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run_en = 1'b0;
  logic [1:0]    mode_sel = 2'b00;
  logic          tick = 1'b0;
  logic          push_valid = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic          fifo_full, fifo_empty;
  logic          trig_we = 1'b0, trig_val = 1'b0, trig_out;
  logic          ack_in = 1'b0;
  logic          req_out, underrun;
  logic [DW-1:0] data_out;

  always #5 clk = ~clk;

  par_out_seq #(.DATA_W(DW), .DEPTH(DEPTH), .STROBE_CYC(SC)) dut (
    .clk(clk), .rst(rst), .run_en(run_en), .mode_sel(mode_sel), .tick(tick),
    .push_valid(push_valid), .push_data(push_data), .fifo_full(fifo_full),
    .fifo_empty(fifo_empty), .trig_we(trig_we), .trig_val(trig_val),
    .trig_out(trig_out), .ack_in(ack_in), .req_out(req_out),
    .data_out(data_out), .underrun(underrun)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [DW-1:0] words [32];

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [DW-1:0] mk_word(input int idx);
    logic [DW-1:0] r;
    r = $urandom;
    return {r[DW-1:8], 8'(idx)};
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) words[i] = mk_word(i);
  endtask

  task automatic push_words(input int n);
    for (int i = 0; i < n; i++) begin
      push_valid = 1'b1;
      push_data  = words[i];
      @(negedge clk);
    end
    push_valid = 1'b0;
  endtask

  // tick sampled at next edge; word visible after the following edge
  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_req();
    for (int k = 0; k < 40; k++) begin
      if (req_out) break;
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 req", req_out, 1'b0);
    check("R1 data", data_out, '0);
    check("R1 trig", trig_out, 1'b0);
    check("R1 underrun", underrun, 1'b0);
    check("R1 empty", fifo_empty, 1'b1);
    check("R1 full", fifo_full, 1'b0);

    // R11 trigger bit
    trig_we = 1'b1; trig_val = 1'b1; @(negedge clk);
    trig_we = 1'b0; trig_val = 1'b0;
    check("R11 set", trig_out, 1'b1);
    @(negedge clk);
    check("R11 hold", trig_out, 1'b1);
    trig_we = 1'b1; @(negedge clk);
    trig_we = 1'b0; trig_val = 1'b1;
    check("R11 clear", trig_out, 1'b0);
    @(negedge clk);
    check("R11 hold low", trig_out, 1'b0);
    trig_val = 1'b0;

    // R3 tick-only mode, random gaps
    fill(12);
    push_words(12);
    mode_sel = 2'b00; run_en = 1'b1;
    for (int i = 0; i < 12; i++) begin
      pulse_tick();
      check("R3 data", data_out, words[i]);
      check("R3 req low", req_out, 1'b0);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    check("R3 drained", fifo_empty, 1'b1);
    run_en = 1'b0; @(negedge clk);

    // R4 strobe mode
    fill(2);
    push_words(2);
    mode_sel = 2'b01; run_en = 1'b1;
    pulse_tick();
    check("R4 data", data_out, words[0]);
    check("R4 req before data", req_out, 1'b0);
    @(negedge clk);
    check("R4 req rise", req_out, 1'b1);
    begin
      int hi;
      hi = 1;
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (req_out) hi++;
      while (req_out && hi < 40) begin
        @(negedge clk);
        if (req_out) hi++;
      end
      check("R4 width", 32'(hi), 32'(SC));
    end
    check("R4 tick ignored data", data_out, words[0]);
    check("R4 tick ignored fifo", fifo_empty, 1'b0);
    pulse_tick();
    check("R4 second word", data_out, words[1]);
    repeat (SC + 3) @(negedge clk);
    run_en = 1'b0; @(negedge clk);

    // R5 R6 R7 handshake with random receiver timing
    fill(10);
    push_words(10);
    mode_sel = 2'b10; run_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      wait_req();
      check("R5 req", req_out, 1'b1);
      check("R5 data", data_out, words[i]);
      repeat ($urandom_range(0, 3)) begin
        @(negedge clk);
        check("R5 hold", req_out, 1'b1);
      end
      ack_in = 1'b1;
      @(negedge clk); check("R6 edge1", req_out, 1'b1);
      @(negedge clk); check("R6 edge2", req_out, 1'b1);
      @(negedge clk); check("R6 edge3", req_out, 1'b0);
      repeat ($urandom_range(2, 6)) begin
        @(negedge clk);
        check("R7 no req while ack", req_out, 1'b0);
      end
      ack_in = 1'b0;
    end
    repeat (6) @(negedge clk);
    check("R5 drained", fifo_empty, 1'b1);
    run_en = 1'b0; @(negedge clk);

    // R10 stop
    fill(2);
    push_words(2);
    mode_sel = 2'b11; run_en = 1'b1;
    wait_req();
    check("R10 req up", req_out, 1'b1);
    run_en = 1'b0;
    @(negedge clk);
    check("R10 req drop", req_out, 1'b0);
    repeat (4) @(negedge clk);
    check("R10 stays low", req_out, 1'b0);
    check("R10 word kept", fifo_empty, 1'b0);
    mode_sel = 2'b00; run_en = 1'b1;
    pulse_tick();
    check("R10 kept word", data_out, words[1]);
    run_en = 1'b0; @(negedge clk);

    // R2 overflow then R9 underrun
    fill(DEPTH + 3);
    push_words(DEPTH + 3);
    check("R2 full", fifo_full, 1'b1);
    mode_sel = 2'b00; run_en = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      pulse_tick();
      check("R2 order", data_out, words[i]);
    end
    check("R2 empty", fifo_empty, 1'b1);
    check("R9 clear before", underrun, 1'b0);
    pulse_tick();
    check("R9 set", underrun, 1'b1);
    check("R9 data kept", data_out, words[DEPTH-1]);
    run_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 sticky", underrun, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule